// File: doc/BRIEF.md
# Three-Wide In-Order Issue Steering Unit

This block sits in the decode stage of a three-wide in-order superscalar core. Every cycle it sees up to three decoded instructions, with slot 0 the oldest. Each instruction carries a class, a destination register and two source registers. The block decides how many of them issue and which execution pipe receives each one. It also raises a one-cycle redirect after a taken branch has issued.

There are three pipes and they are not equal. Pipe X takes ALU operations and branches. Pipes Y and Z take ALU operations, loads and stores. Operands can be routed to any pipe, so the class limits above are the only placement rules. Pipes are handed out greedily, oldest slot first, and an ALU operation takes X whenever X is free.

Data hazards are found in two ways. A per-register scoreboard holds pending results from earlier cycles, and an in-group compare catches dependences between slots of the same cycle. All results are bypassed: an ALU result can be used one cycle after its producer issues, and a load result two cycles after. Issue is strictly in order, so the first slot that cannot go holds back every younger slot. Decode uses the issue count to shift the remaining instructions forward.

Top module: `steer_issue_unit`

## Requirements
- R1: When reset is asserted, the pending-result scoreboard is cleared. A consumer presented right after reset issues even if a load to its source was in flight. With no valid slot, the issue mask is 0, the issue count is 0 and redirect is 0.
- R2: Class encoding is 0 ALU, 1 load, 2 store, 3 branch, and pipe encoding is 0 X, 1 Y, 2 Z. A branch issues only to pipe X. A load or store issues only to pipe Y or pipe Z.
- R3: Pipes are assigned oldest slot first. An ALU operation takes X if it is free, otherwise Y, otherwise Z. A load or store takes Y if it is free, otherwise Z.
- R4: A slot whose class has no free compatible pipe left does not issue. Examples are a third memory operation in a group, a second branch, or a branch behind an ALU operation that took X. No two issued slots share a pipe.
- R5: The issue mask is always a prefix. Slot k issues only if slots 0 to k-1 issue. A slot that is invalid or stalled blocks every younger slot.
- R6: A slot whose source A or source B equals the nonzero destination of an older ALU operation or load in the same group does not issue that cycle.
- R7: An ALU result is available one cycle later. A consumer presented in the cycle after the ALU operation issues is not stalled.
- R8: A load result is available two cycles after the load issues. A consumer presented in the next cycle stalls, and the same consumer issues one cycle after that.
- R9: Register 0 never causes a hazard. Stores and branches write no register, so their destination field is ignored.
- R10: If a branch with its taken flag set issues in cycle t, redirect is 1 in cycle t+1 and nothing issues in that cycle. A branch that is not taken produces no redirect.
- R11: The issue count pipe_sel/issue_count output equals the number of ones in the issue mask. Slot s uses pipe_sel bits [2s+1:2s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NSLOT | Per-slot valid, slot 0 oldest |
| in_class | input | 2*NSLOT | Per-slot class, 2 bits per slot |
| in_dst | input | NSLOT*REG_W | Per-slot destination register |
| in_srca | input | NSLOT*REG_W | Per-slot first source register |
| in_srcb | input | NSLOT*REG_W | Per-slot second source register |
| in_taken | input | NSLOT | Per-slot resolved branch outcome |
| issue_mask | output | NSLOT | Slots that issue this cycle |
| pipe_sel | output | 2*NSLOT | Pipe chosen for each issuing slot |
| issue_count | output | CNT_W | Number of slots consumed |
| redirect | output | 1 | Flush and refetch after a taken branch |

## Verification
A scoreboard counter that is stale or stuck shows up at the ports in the very next cycle. A load consumer either issues one cycle too early or stays blocked when it should go. Because issue is in order, that error also holds back or releases every younger slot. A wrong pipe-busy state during allocation is visible in the same cycle as a pipe_sel value outside the class rules, or as two issued slots sharing a pipe. A lost redirect flag shows one cycle after the taken branch, as a nonzero issue mask where the mask should be empty.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    PIPE_X = 2'd0,
    PIPE_Y = 2'd1,
    PIPE_Z = 2'd2
  } pipe_e;

  typedef struct packed {
    logic  ok;
    pipe_e pipe;
  } pick_t;

  // Greedy choice of a pipe for one class, given the pipes already taken
  // (bit 0 X, bit 1 Y, bit 2 Z).
  function automatic pick_t pick_pipe(op_class_e cls, logic [2:0] taken);
    pick_t r;
    r.ok   = 1'b0;
    r.pipe = PIPE_X;
    unique case (cls)
      CLS_ALU: begin
        if (!taken[0])      begin r.ok = 1'b1; r.pipe = PIPE_X; end
        else if (!taken[1]) begin r.ok = 1'b1; r.pipe = PIPE_Y; end
        else if (!taken[2]) begin r.ok = 1'b1; r.pipe = PIPE_Z; end
      end
      CLS_LOAD, CLS_STORE: begin
        if (!taken[1])      begin r.ok = 1'b1; r.pipe = PIPE_Y; end
        else if (!taken[2]) begin r.ok = 1'b1; r.pipe = PIPE_Z; end
      end
      CLS_BRANCH: begin
        if (!taken[0])      begin r.ok = 1'b1; r.pipe = PIPE_X; end
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic writes_reg(op_class_e cls);
    return (cls == CLS_ALU) || (cls == CLS_LOAD);
  endfunction

  function automatic int unsigned count_ones(logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/steer_scoreboard.sv
module steer_scoreboard
  import steer_pkg::*;
#(
  parameter int NSLOT    = 3,
  parameter int REG_W    = 5,
  parameter int LAT_ALU  = 1,
  parameter int LAT_LOAD = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       wr_en,
  input  logic [NSLOT-1:0]       wr_load,
  input  logic [NSLOT*REG_W-1:0] wr_dst,
  input  logic [NSLOT*REG_W-1:0] q_a,
  input  logic [NSLOT*REG_W-1:0] q_b,
  output logic [NSLOT-1:0]       busy_a,
  output logic [NSLOT-1:0]       busy_b
);
  localparam int NREG = 1 << REG_W;
  localparam int LMAX = (LAT_LOAD > LAT_ALU) ? LAT_LOAD : LAT_ALU;
  localparam int CW   = (LMAX > 2) ? $clog2(LMAX) : 1;
  localparam logic [CW-1:0] WAIT_ALU  = CW'(LAT_ALU - 1);
  localparam logic [CW-1:0] WAIT_LOAD = CW'(LAT_LOAD - 1);

  // Cycles left until the pending result of each register can be bypassed.
  logic [CW-1:0] wait_q [NREG];
  logic [CW-1:0] wait_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++)
      wait_d[r] = (wait_q[r] != '0) ? wait_q[r] - 1'b1 : '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (wr_en[s] && wr_dst[s*REG_W +: REG_W] != '0)
        wait_d[wr_dst[s*REG_W +: REG_W]] = wr_load[s] ? WAIT_LOAD : WAIT_ALU;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) wait_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) wait_q[r] <= wait_d[r];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_query
    assign busy_a[s] = (q_a[s*REG_W +: REG_W] != '0) && (wait_q[q_a[s*REG_W +: REG_W]] != '0);
    assign busy_b[s] = (q_b[s*REG_W +: REG_W] != '0) && (wait_q[q_b[s*REG_W +: REG_W]] != '0);
  end

endmodule

// File: rtl/steer_alloc.sv
module steer_alloc
  import steer_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int REG_W = 5
) (
  input  logic                   hold,
  input  logic [NSLOT-1:0]       in_valid,
  input  logic [2*NSLOT-1:0]     in_class,
  input  logic [NSLOT*REG_W-1:0] in_dst,
  input  logic [NSLOT*REG_W-1:0] in_srca,
  input  logic [NSLOT*REG_W-1:0] in_srcb,
  input  logic [NSLOT-1:0]       busy_a,
  input  logic [NSLOT-1:0]       busy_b,
  output logic [NSLOT-1:0]       issue_mask,
  output logic [2*NSLOT-1:0]     pipe_sel,
  output logic [NSLOT-1:0]       data_stall,
  output logic [NSLOT-1:0]       struct_stall
);
  logic [2:0]  taken;
  logic        go_prev;
  logic        dep;
  op_class_e   cls;
  op_class_e   ocls;
  pick_t       pk;
  logic [REG_W-1:0] odst;

  always_comb begin
    taken        = '0;
    go_prev      = !hold;
    issue_mask   = '0;
    pipe_sel     = '0;
    data_stall   = '0;
    struct_stall = '0;
    dep          = 1'b0;
    cls          = CLS_ALU;
    ocls         = CLS_ALU;
    odst         = '0;
    pk           = '0;
    for (int s = 0; s < NSLOT; s++) begin
      cls = op_class_e'(in_class[2*s +: 2]);
      pk  = pick_pipe(cls, taken);
      dep = 1'b0;
      for (int o = 0; o < NSLOT; o++) begin
        if (o < s) begin
          ocls = op_class_e'(in_class[2*o +: 2]);
          odst = in_dst[o*REG_W +: REG_W];
          if (writes_reg(ocls) && odst != '0 &&
              (in_srca[s*REG_W +: REG_W] == odst || in_srcb[s*REG_W +: REG_W] == odst))
            dep = 1'b1;
        end
      end
      data_stall[s]   = in_valid[s] & (busy_a[s] | busy_b[s] | dep);
      struct_stall[s] = in_valid[s] & !pk.ok;
      if (go_prev && in_valid[s] && !data_stall[s] && !struct_stall[s]) begin
        issue_mask[s]          = 1'b1;
        pipe_sel[2*s +: 2]     = pk.pipe;
        taken[int'(pk.pipe)]   = 1'b1;
      end else begin
        go_prev = 1'b0;
      end
    end
  end

endmodule

// File: rtl/steer_redirect.sv
module steer_redirect
  import steer_pkg::*;
#(
  parameter int NSLOT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   issue_mask,
  input  logic [2*NSLOT-1:0] in_class,
  input  logic [NSLOT-1:0]   in_taken,
  output logic               redirect
);
  logic [NSLOT-1:0] taken_go;

  for (genvar s = 0; s < NSLOT; s++) begin : g_br
    assign taken_go[s] = issue_mask[s] & in_taken[s] &
                         (op_class_e'(in_class[2*s +: 2]) == CLS_BRANCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect <= 1'b0;
    else        redirect <= |taken_go;
  end

endmodule

// File: rtl/steer_issue_unit.sv
module steer_issue_unit
  import steer_pkg::*;
#(
  parameter int NSLOT    = 3,
  parameter int REG_W    = 5,
  parameter int LAT_ALU  = 1,
  parameter int LAT_LOAD = 2,
  localparam int CNT_W   = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       in_valid,
  input  logic [2*NSLOT-1:0]     in_class,
  input  logic [NSLOT*REG_W-1:0] in_dst,
  input  logic [NSLOT*REG_W-1:0] in_srca,
  input  logic [NSLOT*REG_W-1:0] in_srcb,
  input  logic [NSLOT-1:0]       in_taken,
  output logic [NSLOT-1:0]       issue_mask,
  output logic [2*NSLOT-1:0]     pipe_sel,
  output logic [CNT_W-1:0]       issue_count,
  output logic                   redirect
);
  logic [NSLOT-1:0] busy_a;
  logic [NSLOT-1:0] busy_b;
  logic [NSLOT-1:0] wr_en;
  logic [NSLOT-1:0] wr_load;
  logic [NSLOT-1:0] data_stall;
  logic [NSLOT-1:0] struct_stall;

  for (genvar s = 0; s < NSLOT; s++) begin : g_wr
    assign wr_en[s]   = issue_mask[s] & writes_reg(op_class_e'(in_class[2*s +: 2]));
    assign wr_load[s] = op_class_e'(in_class[2*s +: 2]) == CLS_LOAD;
  end

  steer_scoreboard #(
    .NSLOT(NSLOT), .REG_W(REG_W), .LAT_ALU(LAT_ALU), .LAT_LOAD(LAT_LOAD)
  ) u_sb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_load(wr_load), .wr_dst(in_dst),
    .q_a(in_srca), .q_b(in_srcb),
    .busy_a(busy_a), .busy_b(busy_b)
  );

  steer_alloc #(.NSLOT(NSLOT), .REG_W(REG_W)) u_alloc (
    .hold(redirect),
    .in_valid(in_valid), .in_class(in_class), .in_dst(in_dst),
    .in_srca(in_srca), .in_srcb(in_srcb),
    .busy_a(busy_a), .busy_b(busy_b),
    .issue_mask(issue_mask), .pipe_sel(pipe_sel),
    .data_stall(data_stall), .struct_stall(struct_stall)
  );

  steer_redirect #(.NSLOT(NSLOT)) u_redir (
    .clk(clk), .rst_n(rst_n),
    .issue_mask(issue_mask), .in_class(in_class), .in_taken(in_taken),
    .redirect(redirect)
  );

  assign issue_count = CNT_W'(count_ones(32'(issue_mask)));

endmodule

// File: rtl/steer_issue_checks.sv
module steer_issue_checks #(
  parameter int NSLOT = 3,
  parameter int CNT_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NSLOT-1:0] in_class,
  input logic [NSLOT-1:0]   in_taken,
  input logic [NSLOT-1:0]   issue_mask,
  input logic [2*NSLOT-1:0] pipe_sel,
  input logic [CNT_W-1:0]   issue_count,
  input logic               redirect,
  input logic [NSLOT-1:0]   data_stall,
  input logic [NSLOT-1:0]   struct_stall
);
  logic [NSLOT-1:0] br_taken_go;
  for (genvar s = 0; s < NSLOT; s++) begin : g_tk
    assign br_taken_go[s] = issue_mask[s] & in_taken[s] & (in_class[2*s +: 2] == 2'd3);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assert_branch_on_x_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_mask[s] && in_class[2*s +: 2] == 2'd3) |-> pipe_sel[2*s +: 2] == 2'd0);
    assert_mem_off_x_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_mask[s] && (in_class[2*s +: 2] == 2'd1 || in_class[2*s +: 2] == 2'd2))
        |-> (pipe_sel[2*s +: 2] == 2'd1 || pipe_sel[2*s +: 2] == 2'd2));
    if (s > 0) begin : g_pre
      assert_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_mask[s] |-> issue_mask[s-1]);
    end
    for (genvar t = s; t < NSLOT; t++) begin : g_young
      assert_stall_blocks_younger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stall[s] || struct_stall[s]) |-> !issue_mask[t]);
    end
    for (genvar t = s + 1; t < NSLOT; t++) begin : g_pair
      assert_distinct_pipes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask[s] && issue_mask[t]) |-> pipe_sel[2*s +: 2] != pipe_sel[2*t +: 2]);
    end
  end

  assert_count_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_count == CNT_W'($countones(issue_mask)));

  assert_redirect_after_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|br_taken_go) |=> redirect);

  assert_redirect_blocks_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> issue_mask == '0);

endmodule

bind steer_issue_unit steer_issue_checks #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_class(in_class), .in_taken(in_taken),
  .issue_mask(issue_mask), .pipe_sel(pipe_sel), .issue_count(issue_count),
  .redirect(redirect), .data_stall(data_stall), .struct_stall(struct_stall)
);

// File: tb/test_steer_issue_unit.sv
`timescale 1ns/1ps
module test_steer_issue_unit;
  localparam logic [1:0] A = 2'd0, L = 2'd1, S = 2'd2, B = 2'd3;
  localparam logic [1:0] X = 2'd0, Y = 2'd1, Z = 2'd2;
  localparam int VW = 63;
  localparam int NV = 15;

  function automatic logic [VW-1:0] mk(
    logic [2:0] v, logic [1:0] c0, logic [1:0] c1, logic [1:0] c2,
    logic [4:0] d0, logic [4:0] d1, logic [4:0] d2,
    logic [4:0] a0, logic [4:0] a1, logic [4:0] a2,
    logic [4:0] b0, logic [4:0] b1, logic [4:0] b2,
    logic [2:0] em, logic [1:0] e0, logic [1:0] e1, logic [1:0] e2);
    return {v, c2, c1, c0, d2, d1, d0, a2, a1, a0, b2, b1, b0, em, e2, e1, e0};
  endfunction

  // valid, classes, dsts, srcA, srcB, expected mask, expected pipes
  localparam logic [VW-1:0] TBL [NV] = '{
    mk(3'b111, A,A,A, 1,2,3,    4,5,6,   7,8,9,   3'b111, X,Y,Z), // R3 ALU X,Y,Z
    mk(3'b111, L,L,A, 10,11,12, 13,14,15, 16,17,18, 3'b111, Y,Z,X), // R2 R3
    mk(3'b111, L,S,L, 1,2,3,    4,5,6,   7,8,9,   3'b011, Y,Z,X), // R4 third mem
    mk(3'b111, B,B,A, 0,0,1,    2,3,4,   5,6,7,   3'b001, X,X,X), // R4 second branch
    mk(3'b111, A,B,A, 1,0,2,    3,4,5,   6,7,8,   3'b001, X,X,X), // R4 branch w/o X
    mk(3'b111, A,A,A, 5,6,7,    1,5,2,   3,4,8,   3'b001, X,X,X), // R6 srcA dep
    mk(3'b111, L,A,A, 6,7,8,    1,6,2,   3,4,5,   3'b001, Y,X,X), // R6 load in group
    mk(3'b111, A,A,A, 0,1,2,    0,0,3,   0,4,0,   3'b111, X,Y,Z), // R9 r0
    mk(3'b111, S,A,A, 7,8,9,    1,7,2,   3,4,7,   3'b111, Y,X,Z), // R9 store dst
    mk(3'b101, A,A,A, 1,2,3,    4,5,6,   7,8,9,   3'b001, X,X,X), // R5 gap
    mk(3'b111, B,L,L, 0,1,2,    3,4,5,   6,7,8,   3'b111, X,Y,Z), // R2
    mk(3'b111, A,A,L, 1,2,3,    4,5,6,   7,8,9,   3'b111, X,Y,Z), // R3
    mk(3'b111, A,A,A, 8,9,10,   1,2,3,   4,5,8,   3'b011, X,Y,X), // R6 srcB dep
    mk(3'b111, S,A,S, 0,1,0,    2,3,4,   5,6,7,   3'b111, Y,X,Z), // R3 ALU takes X
    mk(3'b000, A,A,A, 1,2,3,    4,5,6,   7,8,9,   3'b000, X,X,X)  // R5 none valid
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  in_valid = '0;
  logic [5:0]  in_class = '0;
  logic [14:0] in_dst = '0, in_srca = '0, in_srcb = '0;
  logic [2:0]  in_taken = '0;
  logic [2:0]  issue_mask;
  logic [5:0]  pipe_sel;
  logic [1:0]  issue_count;
  logic        redirect;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  steer_issue_unit i_steer_issue_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb), .in_taken(in_taken),
    .issue_mask(issue_mask), .pipe_sel(pipe_sel), .issue_count(issue_count),
    .redirect(redirect)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(int s, logic [1:0] c, logic [4:0] d, logic [4:0] a, logic [4:0] b, logic t);
    in_valid[s] = 1'b1;
    in_class[2*s +: 2] = c;
    in_dst[5*s +: 5] = d;
    in_srca[5*s +: 5] = a;
    in_srcb[5*s +: 5] = b;
    in_taken[s] = t;
  endtask

  task automatic idle();
    in_valid = '0; in_class = '0; in_dst = '0; in_srca = '0; in_srcb = '0; in_taken = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 mask after reset", 32'(issue_mask), 0);
    check("R1 count after reset", 32'(issue_count), 0);
    check("R1 redirect after reset", 32'(redirect), 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [5:0] selmask;
      int n;
      v = TBL[i];
      @(negedge clk);
      in_valid = v[62:60]; in_class = v[59:54]; in_dst = v[53:39];
      in_srca = v[38:24]; in_srcb = v[23:9]; in_taken = '0;
      #2;
      selmask = {{2{v[8]}}, {2{v[7]}}, {2{v[6]}}};
      n = 0;
      for (int k = 0; k < 3; k++) if (v[6+k]) n++;
      check($sformatf("R5 table %0d mask", i), 32'(issue_mask), 32'(v[8:6]));
      check($sformatf("R2/R3 table %0d pipes", i), 32'(pipe_sel & selmask), 32'(v[5:0] & selmask));
      check($sformatf("R11 table %0d count", i), 32'(issue_count), n);
      @(negedge clk);
      idle();
    end

    // R8 load-use distance
    @(negedge clk); idle(); put(0, L, 12, 1, 2, 0); #2;
    check("R8 load issues", 32'(issue_mask), 1);
    @(negedge clk); idle(); put(0, A, 13, 12, 3, 0); #2;
    check("R8 consumer stalls next cycle", 32'(issue_mask), 0);
    check("R8 count zero on stall", 32'(issue_count), 0);
    @(negedge clk); #2;
    check("R8 consumer issues two cycles after load", 32'(issue_mask), 1);
    // R7 ALU-use distance
    @(negedge clk); idle(); put(0, A, 20, 1, 2, 0); #2;
    check("R7 producer issues", 32'(issue_mask), 1);
    @(negedge clk); idle(); put(0, A, 21, 3, 20, 0); put(1, L, 22, 20, 4, 0); #2;
    check("R7 ALU result usable next cycle", 32'(issue_mask), 3);

    // R10 taken branch redirect
    @(negedge clk); idle(); put(0, B, 0, 1, 2, 1); put(1, A, 5, 3, 4, 0); #2;
    check("R10 branch group issues", 32'(issue_mask), 3);
    check("R2 branch on X", 32'(pipe_sel[1:0]), 32'(X));
    @(negedge clk); idle(); put(0, A, 6, 1, 2, 0); #2;
    check("R10 redirect high", 32'(redirect), 1);
    check("R10 no issue during redirect", 32'(issue_mask), 0);
    @(negedge clk); #2;
    check("R10 redirect drops", 32'(redirect), 0);
    check("R10 issue resumes", 32'(issue_mask), 1);
    // R10 not-taken branch
    @(negedge clk); idle(); put(0, B, 0, 1, 2, 0); #2;
    check("R10 not-taken issues", 32'(issue_mask), 1);
    @(negedge clk); idle(); #2;
    check("R10 no redirect when not taken", 32'(redirect), 0);

    // R1 reset clears pending load
    @(negedge clk); idle(); put(0, L, 9, 1, 2, 0); #2;
    check("R1 load before reset issues", 32'(issue_mask), 1);
    @(negedge clk); idle();
    rst_n = 1'b0; #1; rst_n = 1'b1;
    put(0, A, 10, 9, 3, 0); #1;
    check("R1 consumer issues after reset", 32'(issue_mask), 1);

    @(negedge clk); idle();
    finish_run();
  end
endmodule